// File: doc/BRIEF.md
# D-PHY Receiver Bring-up Sequencer

This block brings a MIPI D-PHY receiver out of reset and loads its lane configuration through the PHY's serial test-control port. A single start pulse launches the whole routine. The block samples the requested lane count and the high-speed data rate in Mbps on that pulse. It then drives the lane-enable and mode-control levels and pulses the test-port clear. After that it issues a fixed, ordered list of register writes. Each write is a slow two-phase handshake on the test clock: the register code is captured on a falling edge of the test clock while the enable is high, and the data is captured on the following rising edge while the enable is low.

The data rate is converted into a 7-bit frequency band code by searching a table of 39 ascending upper bounds. That band is written into the lane-0 receive-control register. The clear pulse width, the settle delay after it and the minimum time each test-port level is held are all counted in system clock cycles, so the same RTL fits any clock rate. A one-cycle done pulse ends the routine. After it the block waits, idle, for the next start.

Top module: `dphy_rx_bringup`

## Requirements
- R1: Every register write drives the test port in this order: test clock high, code on the 8-bit data bus, enable high, test clock falls with enable high (the code is latched), enable low, data on the bus, test clock rises with enable low (the data is written).
- R2: Before the first write, the clear output is high for at least CLR_CYC cycles while the test clock is high and the enable is low. At least SETTLE_CYC cycles then pass between the clear falling and the first rise of the enable.
- R3: When the clear rises, force-receive is 0, force-stop is 0, turn-request is 0 and turn-disable is 4'hF. These levels are held for the rest of the routine.
- R4: During a routine the lane-enable output has exactly its low N bits set (bit 0 is lane 0). N is the lane count sampled at start. A count of 0 is taken as 1, and a count above 4 is taken as 4.
- R5: Exactly seven writes are issued, as (code, data) pairs in this order: (0x34,0x00), (0x44,band<<1), (0x54,0x00), (0x84,0x00), (0x94,0x00), (0x75,0x04), (0x00,0x00).
- R6: The band is the code of the first table entry, in ascending order of bound, whose upper bound in Mbps is at least the sampled rate. The data of the 0x44 write carries the band in bits 7:1, and bit 0 is 0.
- R7: A sampled rate above 1500 Mbps gives band code 0, so the 0x44 write carries data 0x00.
- R8: Busy is high from the cycle after an accepted start until the routine ends. A start pulse seen while busy is ignored: no restart, and the lane count and rate are not sampled again.
- R9: After the last write, done is high for exactly one cycle, in the cycle where busy is first low, and the test clock is left high.
- R10: Each level of the test clock, enable and data bus is held for at least HOLD_CYC system clock cycles before the next change.
- R11: After reset: busy, done, clear, enable and lane-enable are 0, and the test clock is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run the bring-up routine |
| lane_cnt | input | LCW (3) | Number of data lanes to enable, 1 to 4 |
| rate_mbps | input | RATE_W (12) | High-speed data rate in Mbps |
| busy | output | 1 | Routine in progress |
| done | output | 1 | One-cycle end-of-routine pulse |
| lane_en | output | NUM_LANES (4) | Per-lane enable, lane 0 in bit 0 |
| force_rx | output | NUM_LANES (4) | Force-receive-mode controls |
| force_txstop | output | NUM_LANES (4) | Force-transmit-stop controls |
| turn_req | output | NUM_LANES (4) | Lane turnaround request controls |
| turn_dis | output | NUM_LANES (4) | Lane turnaround disable controls |
| phy_testclr | output | 1 | Test-port clear |
| phy_testclk | output | 1 | Test-port clock |
| phy_testen | output | 1 | Test-port enable (code phase when high) |
| phy_testdin | output | 8 | Test-port code/data bus |

## Verification
A behavioural model of the PHY test port stands on the bench. It latches codes on falling test-clock edges and logs each (code, data) write on rising edges. A wrong step counter or write index in the block therefore shows up as a missing, extra or reordered write, or as a wrong data value. The bench sees this as soon as the routine ends, one done pulse later. A wrong band is seen in the single 0x44 write. The bench sweeps every table bound and every bound plus one, so the band is checked on both sides of every table edge. Timing faults show up at once, in the cycle of the early edge: an edge too soon, a short clear pulse or a short settle gap. Faults in the start handling show as a second clear pulse or as an extra set of writes after a start during busy.

// File: rtl/dphy_seq_pkg.sv
`timescale 1ns/1ps
package dphy_seq_pkg;

    localparam int N_BANDS  = 39;
    localparam int N_WRITES = 7;

    typedef logic [31:0] bound_t;

    // Ascending upper bounds in Mbps and the band code for each.
    localparam bound_t BAND_HI [N_BANDS] = '{
          89,   99,  109,  129,  139,  149,  169,  179,  199,  219,
         239,  249,  269,  299,  329,  359,  399,  449,  499,  549,
         599,  649,  699,  749,  799,  849,  899,  949,  999, 1049,
        1099, 1149, 1199, 1249, 1299, 1349, 1399, 1449, 1500
    };
    localparam logic [6:0] BAND_CODE [N_BANDS] = '{
        7'h00, 7'h10, 7'h20, 7'h01, 7'h11, 7'h21, 7'h02, 7'h12, 7'h22, 7'h03,
        7'h13, 7'h23, 7'h04, 7'h14, 7'h05, 7'h15, 7'h25, 7'h06, 7'h16, 7'h07,
        7'h17, 7'h08, 7'h18, 7'h09, 7'h19, 7'h29, 7'h39, 7'h0a, 7'h1a, 7'h2a,
        7'h3a, 7'h0b, 7'h1b, 7'h2b, 7'h3b, 7'h0c, 7'h1c, 7'h2c, 7'h3c
    };

    typedef struct packed {
        logic [7:0] code;
        logic [7:0] data;
    } tc_wr_t;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_PREP, SQ_CLR, SQ_SETTLE, SQ_ISSUE, SQ_WAIT
    } sq_state_t;

    // Order of these steps is the handshake order on the test port.
    typedef enum logic [2:0] {
        TP_CLK_HI, TP_CODE, TP_EN_HI, TP_CLK_LO, TP_EN_LO, TP_DATA, TP_CLK_RISE
    } tp_step_t;

    // First bound at or above the rate wins; past the table the band is 0.
    function automatic logic [6:0] band_of(input bound_t rate);
        logic hit;
        band_of = '0;
        hit     = 1'b0;
        for (int i = 0; i < N_BANDS; i++) begin
            if (!hit && rate <= BAND_HI[i]) begin
                band_of = BAND_CODE[i];
                hit     = 1'b1;
            end
        end
    endfunction

    // The fixed configuration write list.
    function automatic tc_wr_t wr_entry(input logic [2:0] idx, input logic [6:0] band);
        case (idx)
            3'd0:    wr_entry = '{code: 8'h34, data: 8'h00};
            3'd1:    wr_entry = '{code: 8'h44, data: {band, 1'b0}};
            3'd2:    wr_entry = '{code: 8'h54, data: 8'h00};
            3'd3:    wr_entry = '{code: 8'h84, data: 8'h00};
            3'd4:    wr_entry = '{code: 8'h94, data: 8'h00};
            3'd5:    wr_entry = '{code: 8'h75, data: 8'h04};
            default: wr_entry = '{code: 8'h00, data: 8'h00};
        endcase
    endfunction

endpackage

// File: rtl/dphy_band_lut.sv
`timescale 1ns/1ps
module dphy_band_lut
    import dphy_seq_pkg::*;
#(
    parameter int RATE_W = 12
) (
    input  logic [RATE_W-1:0] rate_mbps,
    output logic [6:0]        band
);

    always_comb begin
        band = band_of(bound_t'(rate_mbps));
    end

endmodule

// File: rtl/dphy_tp_driver.sv
`timescale 1ns/1ps
module dphy_tp_driver
    import dphy_seq_pkg::*;
#(
    parameter int HOLD_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic [7:0] code,
    input  logic [7:0] data,
    output logic       wr_done,
    output logic       testclk,
    output logic       testen,
    output logic [7:0] testdin
);

    localparam int HW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC);

    logic          active;
    tp_step_t      step;
    tp_step_t      nxt;
    tp_step_t      tgt;
    logic          load;
    logic [HW-1:0] hcnt;
    logic [7:0]    code_q;
    logic [7:0]    data_q;

    always_comb begin
        nxt  = tp_step_t'(step + 3'd1);
        tgt  = active ? nxt : TP_CLK_HI;
        load = active ? (hcnt == '0 && step != TP_CLK_RISE) : go;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            step    <= TP_CLK_HI;
            hcnt    <= '0;
            code_q  <= '0;
            data_q  <= '0;
            wr_done <= 1'b0;
            testclk <= 1'b1;
            testen  <= 1'b0;
            testdin <= '0;
        end else begin
            wr_done <= 1'b0;
            if (!active && go) begin
                active <= 1'b1;
                code_q <= code;
                data_q <= data;
            end
            if (active && hcnt != '0) begin
                hcnt <= hcnt - 1'b1;
            end
            if (active && hcnt == '0 && step == TP_CLK_RISE) begin
                active  <= 1'b0;
                wr_done <= 1'b1;
            end
            if (load) begin
                step <= tgt;
                hcnt <= HW'(HOLD_CYC - 1);
                case (tgt)
                    TP_CLK_HI:   testclk <= 1'b1;
                    TP_CODE:     testdin <= code_q;
                    TP_EN_HI:    testen  <= 1'b1;
                    TP_CLK_LO:   testclk <= 1'b0;
                    TP_EN_LO:    testen  <= 1'b0;
                    TP_DATA:     testdin <= data_q;
                    TP_CLK_RISE: testclk <= 1'b1;
                    default:     testclk <= 1'b1;
                endcase
            end
        end
    end

    // Code is captured on the falling test clock, so enable must be high there.
    AST_CODE_EDGE_EN: assert property (@(posedge clk) disable iff (rst)
        $fell(testclk) |-> testen);   // R1
    // Data is captured on the rising test clock, so enable must be low there.
    AST_DATA_EDGE_NOEN: assert property (@(posedge clk) disable iff (rst)
        $rose(testclk) |-> !testen);  // R1
    // Enable and clock never move together.
    AST_NO_JOINT_EDGE: assert property (@(posedge clk) disable iff (rst)
        $changed(testen) |-> $stable(testclk));  // R10

endmodule

// File: rtl/dphy_seq_ctrl.sv
`timescale 1ns/1ps
module dphy_seq_ctrl
    import dphy_seq_pkg::*;
#(
    parameter int NUM_LANES  = 4,
    parameter int LCW        = 3,
    parameter int CLR_CYC    = 20000,
    parameter int SETTLE_CYC = 20000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [LCW-1:0]       lane_cnt,
    input  logic [6:0]           band_in,
    input  logic                 wr_done,
    output logic                 busy,
    output logic                 done,
    output logic [NUM_LANES-1:0] lane_en,
    output logic [NUM_LANES-1:0] force_rx,
    output logic [NUM_LANES-1:0] force_txstop,
    output logic [NUM_LANES-1:0] turn_req,
    output logic [NUM_LANES-1:0] turn_dis,
    output logic                 testclr,
    output logic                 wr_go,
    output logic [7:0]           wr_code,
    output logic [7:0]           wr_data
);

    localparam int TMAX = (CLR_CYC > SETTLE_CYC) ? CLR_CYC : SETTLE_CYC;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int IW   = $clog2(N_WRITES);

    sq_state_t     state;
    logic [TW-1:0] tmr;
    logic [IW-1:0] idx;
    logic [6:0]    band_q;
    tc_wr_t        wr_q;

    function automatic logic [NUM_LANES-1:0] lane_mask(input logic [LCW-1:0] cnt);
        int n;
        if (cnt == '0)                    n = 1;
        else if (int'(cnt) > NUM_LANES)   n = NUM_LANES;
        else                              n = int'(cnt);
        for (int i = 0; i < NUM_LANES; i++) lane_mask[i] = (i < n);
    endfunction

    assign busy    = (state != SQ_IDLE);
    assign wr_code = wr_q.code;
    assign wr_data = wr_q.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= SQ_IDLE;
            tmr          <= '0;
            idx          <= '0;
            band_q       <= '0;
            wr_q         <= '0;
            wr_go        <= 1'b0;
            done         <= 1'b0;
            testclr      <= 1'b0;
            lane_en      <= '0;
            force_rx     <= '0;
            force_txstop <= '0;
            turn_req     <= '0;
            turn_dis     <= '0;
        end else begin
            wr_go <= 1'b0;
            done  <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        lane_en      <= lane_mask(lane_cnt);
                        band_q       <= band_in;
                        force_rx     <= '0;
                        force_txstop <= '0;
                        turn_req     <= '0;
                        turn_dis     <= '1;
                        idx          <= '0;
                        state        <= SQ_PREP;
                    end
                end
                SQ_PREP: begin
                    testclr <= 1'b1;
                    tmr     <= TW'(CLR_CYC - 1);
                    state   <= SQ_CLR;
                end
                SQ_CLR: begin
                    if (tmr == '0) begin
                        testclr <= 1'b0;
                        tmr     <= TW'(SETTLE_CYC - 1);
                        state   <= SQ_SETTLE;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                SQ_SETTLE: begin
                    if (tmr == '0) state <= SQ_ISSUE;
                    else           tmr   <= tmr - 1'b1;
                end
                SQ_ISSUE: begin
                    wr_q  <= wr_entry(3'(idx), band_q);
                    wr_go <= 1'b1;
                    state <= SQ_WAIT;
                end
                SQ_WAIT: begin
                    if (wr_done) begin
                        if (idx == IW'(N_WRITES - 1)) begin
                            done  <= 1'b1;
                            idx   <= '0;
                            state <= SQ_IDLE;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= SQ_ISSUE;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    AST_LANE_MASK_CONTIG: assert property (@(posedge clk) disable iff (rst)
        busy |-> (lane_en != '0) && ((lane_en & (lane_en + 1'b1)) == '0));  // R4
    AST_NO_RESAMPLE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(lane_en) && $stable(band_q)));   // R8
    AST_MODE_AT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        testclr |-> (turn_dis == '1 && turn_req == '0 && force_rx == '0 && force_txstop == '0));  // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);  // R9
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);  // R9

endmodule

// File: rtl/dphy_rx_bringup.sv
`timescale 1ns/1ps
module dphy_rx_bringup
    import dphy_seq_pkg::*;
#(
    parameter int NUM_LANES  = 4,
    parameter int LCW        = $clog2(NUM_LANES + 1),
    parameter int RATE_W     = 12,
    parameter int CLR_CYC    = 20000,
    parameter int SETTLE_CYC = 20000,
    parameter int HOLD_CYC   = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [LCW-1:0]       lane_cnt,
    input  logic [RATE_W-1:0]    rate_mbps,
    output logic                 busy,
    output logic                 done,
    output logic [NUM_LANES-1:0] lane_en,
    output logic [NUM_LANES-1:0] force_rx,
    output logic [NUM_LANES-1:0] force_txstop,
    output logic [NUM_LANES-1:0] turn_req,
    output logic [NUM_LANES-1:0] turn_dis,
    output logic                 phy_testclr,
    output logic                 phy_testclk,
    output logic                 phy_testen,
    output logic [7:0]           phy_testdin
);

    logic [6:0] band;
    logic       wr_go;
    logic       wr_done;
    logic [7:0] wr_code;
    logic [7:0] wr_data;

    dphy_band_lut #(.RATE_W(RATE_W)) u_lut (
        .rate_mbps (rate_mbps),
        .band      (band)
    );

    dphy_seq_ctrl #(
        .NUM_LANES  (NUM_LANES),
        .LCW        (LCW),
        .CLR_CYC    (CLR_CYC),
        .SETTLE_CYC (SETTLE_CYC)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .lane_cnt     (lane_cnt),
        .band_in      (band),
        .wr_done      (wr_done),
        .busy         (busy),
        .done         (done),
        .lane_en      (lane_en),
        .force_rx     (force_rx),
        .force_txstop (force_txstop),
        .turn_req     (turn_req),
        .turn_dis     (turn_dis),
        .testclr      (phy_testclr),
        .wr_go        (wr_go),
        .wr_code      (wr_code),
        .wr_data      (wr_data)
    );

    dphy_tp_driver #(.HOLD_CYC(HOLD_CYC)) u_drv (
        .clk     (clk),
        .rst     (rst),
        .go      (wr_go),
        .code    (wr_code),
        .data    (wr_data),
        .wr_done (wr_done),
        .testclk (phy_testclk),
        .testen  (phy_testen),
        .testdin (phy_testdin)
    );

    AST_CLEAR_CLK_HIGH: assert property (@(posedge clk) disable iff (rst)
        phy_testclr |-> (phy_testclk && !phy_testen));  // R2
    AST_IDLE_CLK_HIGH: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (phy_testclk && !phy_testen && !phy_testclr));  // R9

endmodule

// File: tb/sim_dphy_rx_bringup.sv
`timescale 1ns/1ps
module sim_dphy_rx_bringup;

    localparam int CLR  = 40;
    localparam int SET  = 30;
    localparam int HOLD = 3;
    localparam int RW   = 12;

    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic [2:0] lane_cnt;
    logic [RW-1:0] rate_mbps;
    logic       busy, done;
    logic [3:0] lane_en, force_rx, force_txstop, turn_req, turn_dis;
    logic       testclr, testclk, testen;
    logic [7:0] testdin;

    always #2.5 clk = ~clk;

    dphy_rx_bringup #(
        .NUM_LANES(4), .RATE_W(RW), .CLR_CYC(CLR), .SETTLE_CYC(SET), .HOLD_CYC(HOLD)
    ) u0 (
        .clk(clk), .rst(rst), .start(start), .lane_cnt(lane_cnt), .rate_mbps(rate_mbps),
        .busy(busy), .done(done), .lane_en(lane_en), .force_rx(force_rx),
        .force_txstop(force_txstop), .turn_req(turn_req), .turn_dis(turn_dis),
        .phy_testclr(testclr), .phy_testclk(testclk), .phy_testen(testen),
        .phy_testdin(testdin)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected band table, ascending bounds.
    int ref_hi [39];
    int ref_cd [39];
    initial begin
        ref_hi = '{89,99,109,129,139,149,169,179,199,219,239,249,269,299,329,359,399,449,499,549,
                   599,649,699,749,799,849,899,949,999,1049,1099,1149,1199,1249,1299,1349,1399,1449,1500};
        ref_cd = '{'h00,'h10,'h20,'h01,'h11,'h21,'h02,'h12,'h22,'h03,'h13,'h23,'h04,'h14,'h05,'h15,'h25,
                   'h06,'h16,'h07,'h17,'h08,'h18,'h09,'h19,'h29,'h39,'h0a,'h1a,'h2a,'h3a,'h0b,'h1b,'h2b,
                   'h3b,'h0c,'h1c,'h2c,'h3c};
    end

    function automatic int exp_band(input int r);
        for (int i = 0; i < 39; i++) if (r <= ref_hi[i]) return ref_cd[i];
        return 0;
    endfunction

    // Behavioural model of the PHY test port.
    bit   mon_en = 1'b0;
    logic [7:0] code_l;
    int   nwr;
    int   log_c [8];
    int   log_d [8];

    always @(negedge testclk) if (mon_en && testen) code_l = testdin;
    always @(posedge testclk) begin
        if (mon_en && !testen) begin
            if (nwr < 8) begin
                log_c[nwr] = int'(code_l);
                log_d[nwr] = int'(testdin);
            end
            nwr++;
        end
    end

    // Timing monitor sampled away from the active edge.
    logic [9:0] tp_prev;
    int  hold_since = 1000;
    int  hold_viol, hold_min;
    bit  clr_prev;
    int  clr_len, clr_w, clr_rises, clr_bad;
    bit  gap_on;
    int  gap_cnt, settle_gap;
    logic [15:0] ctl_snap;
    int  done_cnt, done_bad;
    bit  done_prev;

    always @(negedge clk) begin
        cyc++;
        if (mon_en) begin
            if ({testclk, testen, testdin} != tp_prev) begin
                if (hold_since < HOLD) begin
                    hold_viol++;
                    if (hold_since < hold_min) hold_min = hold_since;
                end
                hold_since = 1;
            end else begin
                hold_since++;
            end
            tp_prev = {testclk, testen, testdin};

            if (testclr && !clr_prev) begin
                clr_rises++;
                clr_len  = 0;
                ctl_snap = {turn_dis, turn_req, force_rx, force_txstop};
            end
            if (testclr) begin
                clr_len++;
                if (!testclk || testen) clr_bad++;
            end
            if (gap_on) begin
                gap_cnt++;
                if (testen) begin
                    settle_gap = gap_cnt;
                    gap_on     = 1'b0;
                end
            end
            if (!testclr && clr_prev) begin
                clr_w   = clr_len;
                gap_on  = 1'b1;
                gap_cnt = 0;
            end
            clr_prev = testclr;

            if (done) begin
                done_cnt++;
                if (busy || !testclk || done_prev) done_bad++;
            end
            done_prev = done;
        end
    end

    // Global watchdog.
    always @(posedge clk) begin
        if (cyc > 190000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic run_seq(input int lanes, input int rate, input bit poke);
        int n, mask, band, guard;
        int ec [7];
        int ed [7];
        n    = (lanes == 0) ? 1 : ((lanes > 4) ? 4 : lanes);
        mask = (1 << n) - 1;
        band = exp_band(rate);
        ec = '{'h34, 'h44, 'h54, 'h84, 'h94, 'h75, 'h00};
        ed = '{0, band << 1, 0, 0, 0, 4, 0};

        nwr = 0; hold_viol = 0; hold_min = 1000; clr_w = 0; clr_rises = 0; clr_bad = 0;
        settle_gap = 0; ctl_snap = '0; done_cnt = 0; done_bad = 0;
        for (int k = 0; k < 8; k++) begin log_c[k] = -1; log_d[k] = -1; end

        @(negedge clk);
        start = 1'b1; lane_cnt = 3'(lanes); rate_mbps = RW'(rate);
        @(negedge clk);
        start = 1'b0; lane_cnt = 3'(lanes + 3); rate_mbps = RW'(2000);
        chk(busy == 1'b1, "R8 busy after start", int'(busy), 1);
        if (poke) begin
            repeat (150) @(negedge clk);
            start = 1'b1; lane_cnt = 3'(lanes + 1); rate_mbps = RW'(rate + 700);
            @(negedge clk);
            start = 1'b0;
            chk(busy == 1'b1, "R8 still busy at ignored start", int'(busy), 1);
        end
        guard = 0;
        while (done_cnt == 0 && guard < 4000) begin
            @(negedge clk);
            guard++;
            if (busy) chk(lane_en == 4'(mask), "R4 lane_en during run", int'(lane_en), mask);
        end
        chk(guard < 4000, "R9 done reached (watchdog)", guard, 4000);
        repeat (3) @(negedge clk);

        chk(nwr == 7, "R5 write count", nwr, 7);
        for (int k = 0; k < 7; k++) begin
            chk(log_c[k] == ec[k], $sformatf("R5 code of write %0d", k), log_c[k], ec[k]);
            if (k == 1)
                chk(log_d[k] == ed[k], $sformatf("R6 R7 band data rate %0d", rate), log_d[k], ed[k]);
            else
                chk(log_d[k] == ed[k], $sformatf("R1 data of write %0d", k), log_d[k], ed[k]);
        end
        chk(clr_rises == 1, "R8 single clear pulse", clr_rises, 1);
        chk(clr_w >= CLR, "R2 clear width", clr_w, CLR);
        chk(clr_bad == 0, "R2 clock high and enable low in clear", clr_bad, 0);
        chk(settle_gap >= SET, "R2 settle gap", settle_gap, SET);
        chk(ctl_snap == 16'hF000, "R3 mode controls at clear", int'(ctl_snap), 'hF000);
        chk(turn_dis == 4'hF && force_rx == 0 && force_txstop == 0 && turn_req == 0,
            "R3 mode controls after run", int'({turn_dis, turn_req, force_rx, force_txstop}), 'hF000);
        chk(hold_viol == 0, "R10 hold violations", hold_min, HOLD);
        chk(done_cnt == 1 && done_bad == 0, "R9 single done pulse", done_cnt * 10 + done_bad, 10);
        chk(!busy && testclk, "R9 idle with test clock high", int'({busy, testclk}), 1);
        chk(lane_en == 4'(mask), "R4 lane_en after run", int'(lane_en), mask);
    endtask

    initial begin
        int i;
        rst = 1'b1; start = 1'b0; lane_cnt = 3'd1; rate_mbps = '0;
        nwr = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(busy == 0 && done == 0, "R11 busy/done after reset", int'({busy, done}), 0);
        chk(lane_en == 0 && testclr == 0, "R11 lane_en/clear after reset", int'({lane_en, testclr}), 0);
        chk(testclk == 1 && testen == 0, "R11 test clock/enable after reset", int'({testclk, testen}), 2);
        tp_prev  = {testclk, testen, testdin};
        clr_prev = testclr;
        mon_en   = 1'b1;

        i = 0;
        run_seq(1, 0, 1'b0);
        for (int b = 0; b < 39; b++) begin
            run_seq((i % 8), ref_hi[b], (i % 5) == 2);
            i++;
            run_seq((i % 8), ref_hi[b] + 1, (i % 5) == 2);
            i++;
        end
        run_seq(4, 1501, 1'b1);   // R7 just above the table
        run_seq(0, 4095, 1'b0);   // R7 far above, R4 zero lanes
        run_seq(7, 1, 1'b0);      // R4 count above 4

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule